// File: doc/BRIEF.md
# Fault Latch and Driver-Enable Supervisor

This block sits between the analog protection monitors of a multi-channel motor and actuator driver and the rest of the digital control. It takes one-cycle event strobes for supply faults, short circuits, overcurrent and serial-link timeout, and level inputs for thermal pre-alert and thermal trip. It keeps each of these as a sticky flag that software reads through a small register port. A summary status byte is formed from the flags, and a single self-clearing command wipes them all.

The block also owns the driver-enable register for seven output channels: tilt, focus, track, spindle, sled, load and CSW. It combines that register with the mute pin, the sleep control, the shared track/load resource and the protection holds to produce per-channel effective enables and Hi-Z requests. A monitor-select register routes chosen status signals to one general-purpose output pin. The mute pin is asynchronous. It is synchronized and must stay low for a set number of clock cycles before it counts.

Top module: `fault_supervisor`

Register port: `addr_i` selects 0 drive, 1 options, 2 monitor select, 3 clear command (write only, reads 0), 4 power flags, 5 thermal flags, 6 protection flags, 7 status. Drive register bits [6:0] are the channel enables (0 tilt, 1 focus, 2 track, 3 spindle, 4 sled, 5 load, 6 CSW), and bit 7 is the awake bit (0 = sleep). These bit positions also index `en_o` and `hiz_o`.

## Requirements
- R1: A strobe on `pwr_ev_i` sets the matching power flag on the next clock edge. The flags read at address 4 as: bit0 overvoltage, bit1 LDO-feedback undervoltage, bit2 I/O-supply undervoltage, bit3 core undervoltage, bit4 main-supply undervoltage, bit5 mute detected. A flag stays set until a clear command.
- R2: Thermal flags latch while their level input is high and read at address 5 as: bit0 actuator alert, bit1 spindle alert, bit2 actuator trip, bit3 spindle trip. Protection flags latch on their strobes and read at address 6 as: bits[3:0] short circuit on actuator, load, sled and spindle (in that order), bit4 CSW overcurrent, bit5 load overcurrent.
- R3: Writing address 3 with bit0 = 1 clears every power, thermal and protection flag and the serial-timeout flag in one cycle, so status bits [5:1] read 0. An event in the same cycle as the clear still sets its flag. Address 3 reads as 0.
- R4: The mute pin counts only after MUTE_QUAL_CYCLES consecutive low samples. Its effect appears at the ports after the second clock edge that follows the last of those samples. It acts once per low episode and sets power flag bit5.
- R5: On a mute event the tilt, focus, track, spindle and sled enables clear unless option bit0 (global no-reset) is 1. The load enable also clears when option bit2 (load half-channel mode) is 1 and bit0 is 0. The CSW enable clears unless option bit1 is 1, whatever bit0 holds. The mute clearing overrides a drive-register write made in the same cycle.
- R6: While drive bit7 is 0, the stored channel bits are forced to 0, every `en_o` bit is 0 and every `hiz_o` bit is 1.
- R7: When load is effectively enabled, `en_o[2]` (track) is 0 whatever the track bit holds.
- R8: A short-circuit strobe forces Hi-Z on its channel group from the next cycle for exactly HIZ_HOLD_CYCLES cycles. The groups are actuator → tilt, focus and track, and load, sled and spindle → their own channel. A new strobe during the hold restarts it.
- R9: A CSW overcurrent strobe holds `hiz_o[6]` for the same window. An actuator thermal trip level forces Hi-Z on every channel except spindle, and a spindle trip forces Hi-Z on spindle. Both act only while the level is high.
- R10: Status at address 7: bit7 actuator-timer fault input, bit6 end-detect input, bit5 latched serial timeout, bit4 any power flag, bit3 any thermal trip flag, bit2 any protection flag, bit1 any thermal alert flag, bit0 0.
- R11: `gpo_o` is the OR of status bits [7:1] masked by monitor-select bits [7:1]. It is 0 when none is selected.
- R12: After reset all registers and flags are 0, `en_o` is 0, `hiz_o` is all ones and `gpo_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mute_n_i | input | 1 | Asynchronous mute pin, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address for write and read |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| pwr_ev_i | input | 5 | Supply fault strobes |
| therm_alert_i | input | 2 | Thermal pre-alert levels (0 actuator, 1 spindle) |
| therm_trip_i | input | 2 | Thermal trip levels (0 actuator, 1 spindle) |
| scp_ev_i | input | 4 | Short-circuit strobes (actuator, load, sled, spindle) |
| ocp_ev_i | input | 2 | Overcurrent strobes (0 CSW, 1 load) |
| sif_to_ev_i | input | 1 | Serial-link timeout strobe |
| acttimer_flt_i | input | 1 | Actuator-timer fault level |
| enddet_i | input | 1 | Sled end-detect level |
| en_o | output | 7 | Effective per-channel enables |
| hiz_o | output | 7 | Per-channel Hi-Z requests |
| gpo_o | output | 1 | Monitor output pin |

## Verification
The bench builds the block with MUTE_QUAL_CYCLES = 4 and HIZ_HOLD_CYCLES = 12, in place of the default microsecond and millisecond counts. With these values the mute qualification edge can be probed with a run one sample too short and then with a full run. The last cycle of a protection hold and a restart partway through a hold both occur within a few dozen clocks. The small mute window also makes it practical to line up a drive-register write with the exact cycle in which a mute event lands.

// File: rtl/fsup_pkg.sv
package fsup_pkg;

  localparam int unsigned NUM_CH    = 7;
  localparam int unsigned AWAKE_BIT = 7;

  localparam int unsigned CH_TLT  = 0;
  localparam int unsigned CH_FCS  = 1;
  localparam int unsigned CH_TRK  = 2;
  localparam int unsigned CH_SPM  = 3;
  localparam int unsigned CH_SLD  = 4;
  localparam int unsigned CH_LOAD = 5;
  localparam int unsigned CH_CSW  = 6;

  localparam int unsigned PWR_W   = 6;
  localparam int unsigned THERM_W = 4;
  localparam int unsigned PROT_W  = 6;
  localparam int unsigned SCP_N   = 4;
  localparam int unsigned HOLD_N  = SCP_N + 1;
  localparam int unsigned OPT_W   = 3;

  localparam int unsigned OPT_NORST_ALL = 0;
  localparam int unsigned OPT_NORST_CSW = 1;
  localparam int unsigned OPT_LOAD_HALF = 2;
  localparam int unsigned CLR_FLAGS_BIT = 0;

  typedef enum logic [2:0] {
    RA_DRV   = 3'd0,
    RA_OPT   = 3'd1,
    RA_MON   = 3'd2,
    RA_CLR   = 3'd3,
    RA_PWR   = 3'd4,
    RA_THERM = 3'd5,
    RA_PROT  = 3'd6,
    RA_STAT  = 3'd7
  } reg_addr_e;

endpackage

// File: rtl/fsup_mute_filter.sv
module fsup_mute_filter #(
  parameter int unsigned QUAL_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mute_n_i,
  output logic mute_evt_o
);

  localparam int unsigned CW = $clog2(QUAL_CYCLES + 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(QUAL_CYCLES);
  localparam logic [CW-1:0] CNT_LAST = CW'(QUAL_CYCLES - 1);

  logic          sync1_q, sync2_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  // two-stage synchronizer, idles high (not muted)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
    end else begin
      sync1_q <= mute_n_i;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (sync2_q)
      cnt_d = '0;
    else if (cnt_q != CNT_MAX)
      cnt_d = cnt_q + 1'b1;
  end

  assign cnt_en = sync2_q ? (cnt_q != '0) : (cnt_q != CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  // one pulse per low episode, when the run reaches the qualifying length
  assign mute_evt_o = !sync2_q && (cnt_q == CNT_LAST);

endmodule

// File: rtl/fsup_hiz_hold.sv
module fsup_hiz_hold #(
  parameter int unsigned HOLD_CYCLES = 160000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic hold_o
);

  localparam int unsigned CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(HOLD_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    if (trig_i)
      cnt_d = CNT_LOAD;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  assign cnt_en = trig_i || (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  assign hold_o = (cnt_q != '0);

endmodule

// File: rtl/fsup_flag_bank.sv
module fsup_flag_bank #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] flags_o
);

  logic [W-1:0] flags_q, flags_d;
  logic         upd_en;

  // a set in the clearing cycle wins over the clear
  always_comb begin
    flags_d = (clr_i ? '0 : flags_q) | set_i;
  end

  assign upd_en = clr_i || (set_i != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flags_q <= '0;
    else if (upd_en)
      flags_q <= flags_d;
  end

  assign flags_o = flags_q;

endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
  import fsup_pkg::*;
#(
  parameter int unsigned MUTE_QUAL_CYCLES = 2000,
  parameter int unsigned HIZ_HOLD_CYCLES  = 160000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mute_n_i,
  input  logic        wr_en_i,
  input  logic [2:0]  addr_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  input  logic [4:0]  pwr_ev_i,
  input  logic [1:0]  therm_alert_i,
  input  logic [1:0]  therm_trip_i,
  input  logic [3:0]  scp_ev_i,
  input  logic [1:0]  ocp_ev_i,
  input  logic        sif_to_ev_i,
  input  logic        acttimer_flt_i,
  input  logic        enddet_i,
  output logic [6:0]  en_o,
  output logic [6:0]  hiz_o,
  output logic        gpo_o
);

  reg_addr_e addr;
  assign addr = reg_addr_e'(addr_i);

  logic wr_drv, wr_opt, wr_mon, wr_clr;
  assign wr_drv = wr_en_i && (addr == RA_DRV);
  assign wr_opt = wr_en_i && (addr == RA_OPT);
  assign wr_mon = wr_en_i && (addr == RA_MON);
  assign wr_clr = wr_en_i && (addr == RA_CLR);

  logic clr_flags;
  assign clr_flags = wr_clr && wdata_i[CLR_FLAGS_BIT];

  // ---------------- mute qualification ----------------
  logic mute_evt;

  fsup_mute_filter #(.QUAL_CYCLES(MUTE_QUAL_CYCLES)) u_mute (
    .clk        (clk),
    .rst_n      (rst_n),
    .mute_n_i   (mute_n_i),
    .mute_evt_o (mute_evt)
  );

  // ---------------- sticky flags ----------------
  logic [PWR_W-1:0]   pwr_flags;
  logic [THERM_W-1:0] therm_flags;
  logic [PROT_W-1:0]  prot_flags;
  logic [0:0]         sif_flag;

  fsup_flag_bank #(.W(PWR_W)) u_pwr_flags (
    .clk(clk), .rst_n(rst_n), .set_i({mute_evt, pwr_ev_i}),
    .clr_i(clr_flags), .flags_o(pwr_flags)
  );

  fsup_flag_bank #(.W(THERM_W)) u_therm_flags (
    .clk(clk), .rst_n(rst_n), .set_i({therm_trip_i, therm_alert_i}),
    .clr_i(clr_flags), .flags_o(therm_flags)
  );

  fsup_flag_bank #(.W(PROT_W)) u_prot_flags (
    .clk(clk), .rst_n(rst_n), .set_i({ocp_ev_i, scp_ev_i}),
    .clr_i(clr_flags), .flags_o(prot_flags)
  );

  fsup_flag_bank #(.W(1)) u_sif_flag (
    .clk(clk), .rst_n(rst_n), .set_i(sif_to_ev_i),
    .clr_i(clr_flags), .flags_o(sif_flag)
  );

  // ---------------- Hi-Z hold timers ----------------
  logic [HOLD_N-1:0] hold_trig, hold_act;
  assign hold_trig = {ocp_ev_i[0], scp_ev_i};

  for (genvar g = 0; g < HOLD_N; g++) begin : g_hold
    fsup_hiz_hold #(.HOLD_CYCLES(HIZ_HOLD_CYCLES)) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .trig_i (hold_trig[g]),
      .hold_o (hold_act[g])
    );
  end

  // ---------------- configuration registers ----------------
  logic [7:0]       drv_q, drv_d;
  logic             drv_en;
  logic [OPT_W-1:0] opt_q;
  logic [7:0]       mon_q;

  always_comb begin
    drv_d = drv_q;
    if (wr_drv)
      drv_d = wdata_i;
    if (mute_evt) begin
      if (!opt_q[OPT_NORST_ALL]) begin
        drv_d[CH_TLT] = 1'b0;
        drv_d[CH_FCS] = 1'b0;
        drv_d[CH_TRK] = 1'b0;
        drv_d[CH_SPM] = 1'b0;
        drv_d[CH_SLD] = 1'b0;
        if (opt_q[OPT_LOAD_HALF])
          drv_d[CH_LOAD] = 1'b0;
      end
      if (!opt_q[OPT_NORST_CSW])
        drv_d[CH_CSW] = 1'b0;
    end
    if (!drv_d[AWAKE_BIT])
      drv_d[NUM_CH-1:0] = '0;
  end

  assign drv_en = wr_drv || mute_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      drv_q <= '0;
    else if (drv_en)
      drv_q <= drv_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      opt_q <= '0;
    else if (wr_opt)
      opt_q <= wdata_i[OPT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mon_q <= '0;
    else if (wr_mon)
      mon_q <= wdata_i;
  end

  // ---------------- effective enables and Hi-Z ----------------
  logic awake, load_on;
  assign awake   = drv_q[AWAKE_BIT];
  assign load_on = awake && drv_q[CH_LOAD];

  always_comb begin
    en_o = awake ? drv_q[NUM_CH-1:0] : '0;
    if (load_on)
      en_o[CH_TRK] = 1'b0;
  end

  logic [NUM_CH-1:0] guard;

  always_comb begin
    guard = '0;
    guard[CH_TLT]  = hold_act[0];
    guard[CH_FCS]  = hold_act[0];
    guard[CH_TRK]  = hold_act[0];
    guard[CH_LOAD] = hold_act[1];
    guard[CH_SLD]  = hold_act[2];
    guard[CH_SPM]  = hold_act[3];
    guard[CH_CSW]  = hold_act[4];
    for (int c = 0; c < NUM_CH; c++) begin
      if (c == CH_SPM)
        guard[c] = guard[c] | therm_trip_i[1];
      else
        guard[c] = guard[c] | therm_trip_i[0];
    end
    hiz_o = ~en_o | guard;
  end

  // ---------------- status, monitor pin, readback ----------------
  logic [7:0] status;

  always_comb begin
    status    = '0;
    status[7] = acttimer_flt_i;
    status[6] = enddet_i;
    status[5] = sif_flag[0];
    status[4] = |pwr_flags;
    status[3] = |therm_flags[3:2];
    status[2] = |prot_flags;
    status[1] = |therm_flags[1:0];
  end

  assign gpo_o = |(mon_q[7:1] & status[7:1]);

  always_comb begin
    unique case (addr)
      RA_DRV:   rdata_o = drv_q;
      RA_OPT:   rdata_o = {{(8-OPT_W){1'b0}}, opt_q};
      RA_MON:   rdata_o = mon_q;
      RA_CLR:   rdata_o = '0;
      RA_PWR:   rdata_o = {{(8-PWR_W){1'b0}}, pwr_flags};
      RA_THERM: rdata_o = {{(8-THERM_W){1'b0}}, therm_flags};
      RA_PROT:  rdata_o = {{(8-PROT_W){1'b0}}, prot_flags};
      RA_STAT:  rdata_o = status;
      default:  rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/fsup_checker.sv
module fsup_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       clr_cmd,
  input logic [4:0] pwr_ev_i,
  input logic [3:0] scp_ev_i,
  input logic [6:0] en_o,
  input logic [6:0] hiz_o,
  input logic       gpo_o,
  input logic       mute_evt,
  input logic [7:0] drv_q,
  input logic [2:0] opt_q,
  input logic [7:0] mon_q,
  input logic [5:0] pwr_flags
);

  // R1: power flags only fall through a clear command
  a_r1_pwr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_cmd |=> ((pwr_flags & $past(pwr_flags)) == $past(pwr_flags)));

  // R3: a clear with no concurrent event empties the power flags
  a_r3_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_cmd && (pwr_ev_i == 5'd0) && !mute_evt) |=> (pwr_flags == 6'd0));

  // R4: a qualified mute records the mute flag
  a_r4_mute_flag: assert property (@(posedge clk) disable iff (!rst_n)
    mute_evt |=> pwr_flags[5]);

  // R5: a qualified mute without global opt-out clears the five base enables
  a_r5_mute_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_evt && !opt_q[0]) |=> (drv_q[4:0] == 5'd0));

  // R6: sleep disables and floats every channel
  a_r6_sleep_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_q[7] |-> ((en_o == 7'd0) && (hiz_o == 7'h7f)));

  // R7: load and track never drive together
  a_r7_load_over_track: assert property (@(posedge clk) disable iff (!rst_n)
    en_o[5] |-> !en_o[2]);

  // R8: a spindle short circuit floats the spindle in the next cycle
  a_r8_scp_spm_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    scp_ev_i[3] |=> hiz_o[3]);

  // R11: nothing selected keeps the monitor pin low
  a_r11_gpo_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_q[7:1] == 7'd0) |-> !gpo_o);

endmodule

bind fault_supervisor fsup_checker i_fsup_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .clr_cmd   (clr_flags),
  .pwr_ev_i  (pwr_ev_i),
  .scp_ev_i  (scp_ev_i),
  .en_o      (en_o),
  .hiz_o     (hiz_o),
  .gpo_o     (gpo_o),
  .mute_evt  (mute_evt),
  .drv_q     (drv_q),
  .opt_q     (opt_q),
  .mon_q     (mon_q),
  .pwr_flags (pwr_flags)
);

// File: tb/test_fault_supervisor.sv
module test_fault_supervisor;

  localparam int CLK_PERIOD = 10;
  localparam int MQ = 4;
  localparam int HH = 12;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mute_n = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd7;
  logic [7:0] wdata = 8'd0;
  logic [4:0] pwr_ev = '0;
  logic [1:0] t_alert = '0, t_trip = '0;
  logic [3:0] scp_ev = '0;
  logic [1:0] ocp_ev = '0;
  logic       sif_ev = 1'b0, actt = 1'b0, enddet = 1'b0;
  logic [7:0] rdata;
  logic [6:0] en, hiz;
  logic       gpo;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_supervisor #(.MUTE_QUAL_CYCLES(MQ), .HIZ_HOLD_CYCLES(HH)) i_fault_supervisor (
    .clk(clk), .rst_n(rst_n), .mute_n_i(mute_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pwr_ev_i(pwr_ev), .therm_alert_i(t_alert),
    .therm_trip_i(t_trip), .scp_ev_i(scp_ev), .ocp_ev_i(ocp_ev), .sif_to_ev_i(sif_ev),
    .acttimer_flt_i(actt), .enddet_i(enddet), .en_o(en), .hiz_o(hiz), .gpo_o(gpo)
  );

  // ---------------- behavioural reference ----------------
  bit [7:0] m_drv = 0, m_mon = 0;
  bit [2:0] m_opt = 0;
  bit [5:0] m_pwr = 0, m_prot = 0;
  bit [3:0] m_therm = 0;
  bit       m_sif = 0;
  int       m_hold [5] = '{0, 0, 0, 0, 0};
  int       low_run = 0;
  bit       pend1 = 0, pend2 = 0;

  always @(posedge clk) begin
    bit apply;
    bit clr;
    bit [7:0] nd;
    if (!rst_n) begin
      m_drv = 0; m_mon = 0; m_opt = 0; m_pwr = 0; m_prot = 0; m_therm = 0; m_sif = 0;
      for (int i = 0; i < 5; i++) m_hold[i] = 0;
      low_run = 0; pend1 = 0; pend2 = 0;
    end else begin
      apply = pend2;
      pend2 = pend1;
      if (mute_n) low_run = 0; else low_run = low_run + 1;
      pend1 = (low_run == MQ);
      nd = m_drv;
      if (wr_en && addr == 3'd0) nd = wdata;
      if (apply) begin
        if (!m_opt[0]) begin
          nd[4:0] = 5'd0;
          if (m_opt[2]) nd[5] = 1'b0;
        end
        if (!m_opt[1]) nd[6] = 1'b0;
      end
      if (!nd[7]) nd[6:0] = 7'd0;
      m_drv = nd;
      if (wr_en && addr == 3'd1) m_opt = wdata[2:0];
      if (wr_en && addr == 3'd2) m_mon = wdata;
      clr = wr_en && addr == 3'd3 && wdata[0];
      if (clr) begin m_pwr = 0; m_therm = 0; m_prot = 0; m_sif = 0; end
      m_pwr   = m_pwr | {apply, pwr_ev};
      m_therm = m_therm | {t_trip, t_alert};
      m_prot  = m_prot | {ocp_ev, scp_ev};
      m_sif   = m_sif | sif_ev;
      for (int i = 0; i < 5; i++) begin
        bit trg;
        trg = (i < 4) ? scp_ev[i] : ocp_ev[0];
        if (trg) m_hold[i] = HH;
        else if (m_hold[i] > 0) m_hold[i] = m_hold[i] - 1;
      end
    end
  end

  function automatic bit [7:0] exp_status();
    bit [7:0] s;
    s = {actt, enddet, m_sif, |m_pwr, |m_therm[3:2], |m_prot, |m_therm[1:0], 1'b0};
    return s;
  endfunction

  function automatic bit [6:0] exp_en();
    bit [6:0] e;
    e = m_drv[7] ? m_drv[6:0] : 7'd0;
    if (m_drv[7] && m_drv[5]) e[2] = 1'b0;
    return e;
  endfunction

  function automatic bit [6:0] exp_hiz();
    bit [6:0] g;
    g[0] = m_hold[0] > 0; g[1] = m_hold[0] > 0; g[2] = m_hold[0] > 0;
    g[5] = m_hold[1] > 0; g[4] = m_hold[2] > 0; g[3] = m_hold[3] > 0;
    g[6] = m_hold[4] > 0;
    for (int c = 0; c < 7; c++) g[c] = g[c] | ((c == 3) ? t_trip[1] : t_trip[0]);
    return ~exp_en() | g;
  endfunction

  function automatic bit [7:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_drv;
      3'd1: return {5'd0, m_opt};
      3'd2: return m_mon;
      3'd3: return 8'd0;
      3'd4: return {2'd0, m_pwr};
      3'd5: return {4'd0, m_therm};
      3'd6: return {2'd0, m_prot};
      default: return exp_status();
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (!finished) begin
      chk("R6 en_o", {1'b0, en}, {1'b0, exp_en()});
      chk("R8 hiz_o", {1'b0, hiz}, {1'b0, exp_hiz()});
      chk("R11 gpo_o", {7'd0, gpo}, {7'd0, exp_status()[7:1] != 7'd0 && (m_mon[7:1] & exp_status()[7:1]) != 7'd0});
      chk("R10 rdata_o", rdata, exp_rd(addr));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    tick(1);
    wr_en = 1'b0; addr = 3'd7;
  endtask

  task automatic rd(input logic [2:0] a, input string tag, input logic [7:0] exp);
    addr = a;
    @(negedge clk);
    chk(tag, rdata, exp);
    tick(1);
    addr = 3'd7;
  endtask

  task automatic now_chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    @(negedge clk);
    chk(tag, act, exp);
    tick(1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R12 reset state
    addr = 3'd0;
    @(negedge clk);
    chk("R12 drv", rdata, 8'h00);
    chk("R12 en", {1'b0, en}, 8'h00);
    chk("R12 hiz", {1'b0, hiz}, 8'h7f);
    chk("R12 gpo", {7'd0, gpo}, 8'h00);
    tick(1);

    // R6 sleep masks stored enables
    wr(3'd0, 8'h7f);
    rd(3'd0, "R6 drv asleep", 8'h00);
    now_chk("R6 hiz asleep", {1'b0, hiz}, 8'h7f);

    // R7 load beats track
    wr(3'd0, 8'hbf);
    now_chk("R7 en load+track", {1'b0, en}, 8'h3b);
    wr(3'd0, 8'h9f);
    now_chk("R7 en track alone", {1'b0, en}, 8'h1f);

    // R1 power flags
    pwr_ev = 5'b10101; tick(1); pwr_ev = 0;
    tick(3);
    rd(3'd4, "R1 pwr flags", 8'h15);
    rd(3'd7, "R10 status pwr", 8'h10);

    // R2 / R9 thermal
    t_alert = 2'b01; tick(1); t_alert = 0;
    t_trip = 2'b10; tick(1);
    now_chk("R9 spm trip hiz", {7'd0, hiz[3]}, 8'h01);
    t_trip = 0; tick(1);
    now_chk("R9 spm trip released", {7'd0, hiz[3]}, 8'h00);
    rd(3'd5, "R2 therm flags", 8'h09);
    rd(3'd7, "R10 status therm", 8'h1a);

    // R8 short-circuit hold on sled
    scp_ev = 4'b0100; tick(1); scp_ev = 0;
    now_chk("R8 sled hiz start", {7'd0, hiz[4]}, 8'h01);
    tick(HH - 2);
    now_chk("R8 sled hiz last", {7'd0, hiz[4]}, 8'h01);
    now_chk("R8 sled hiz end", {7'd0, hiz[4]}, 8'h00);
    // restart within hold
    scp_ev = 4'b0001; tick(1); scp_ev = 0;
    tick(5);
    scp_ev = 4'b0001; tick(1); scp_ev = 0;
    tick(HH - 2);
    now_chk("R8 act hiz restarted", {5'd0, hiz[2:0]}, 8'h07);
    rd(3'd6, "R2 prot flags", 8'h05);

    // R9 CSW overcurrent hold
    wr(3'd0, 8'hdf);
    ocp_ev = 2'b01; tick(1); ocp_ev = 0;
    now_chk("R9 csw hiz", {7'd0, hiz[6]}, 8'h01);
    tick(HH + 1);
    now_chk("R9 csw back", {7'd0, hiz[6]}, 8'h00);

    // R11 monitor pin
    sif_ev = 1'b1; tick(1); sif_ev = 0;
    now_chk("R11 gpo none", {7'd0, gpo}, 8'h00);
    wr(3'd2, 8'h10);
    now_chk("R11 gpo pwr", {7'd0, gpo}, 8'h01);
    wr(3'd2, 8'h80);
    now_chk("R11 gpo acttimer low", {7'd0, gpo}, 8'h00);
    actt = 1'b1; tick(1);
    now_chk("R11 gpo acttimer high", {7'd0, gpo}, 8'h01);
    actt = 1'b0; enddet = 1'b1;
    rd(3'd7, "R10 status full", 8'h7e);
    enddet = 1'b0;

    // R3 clear, with a concurrent event
    wr(3'd3, 8'h01);
    rd(3'd7, "R3 status cleared", 8'h00);
    rd(3'd6, "R3 prot cleared", 8'h00);
    pwr_ev = 5'b00001;
    wr(3'd3, 8'h01);
    pwr_ev = 0;
    rd(3'd4, "R3 event beats clear", 8'h01);
    rd(3'd3, "R3 clear reads zero", 8'h00);
    wr(3'd3, 8'h01);

    // R4 short low run is ignored
    wr(3'd0, 8'hff);
    mute_n = 1'b0; tick(MQ - 1); mute_n = 1'b1;
    tick(4);
    rd(3'd0, "R4 short mute ignored", 8'hff);
    rd(3'd4, "R4 no mute flag", 8'h00);

    // R4 / R5 qualified mute, default options
    mute_n = 1'b0; tick(MQ + 3);
    rd(3'd0, "R5 mute default", 8'ha0);
    rd(3'd4, "R4 mute flag", 8'h20);
    wr(3'd0, 8'hff);
    tick(3);
    rd(3'd0, "R4 once per episode", 8'hff);
    mute_n = 1'b1; tick(4);

    // R5 load half-channel
    wr(3'd1, 8'h04);
    mute_n = 1'b0; tick(MQ + 3); mute_n = 1'b1; tick(4);
    rd(3'd0, "R5 mute load half", 8'h80);

    // R5 global opt-out, CSW still cleared
    wr(3'd0, 8'hff);
    wr(3'd1, 8'h01);
    mute_n = 1'b0; tick(MQ + 3); mute_n = 1'b1; tick(4);
    rd(3'd0, "R5 norst all", 8'hbf);

    // R5 both opt-outs
    wr(3'd0, 8'hff);
    wr(3'd1, 8'h03);
    mute_n = 1'b0; tick(MQ + 3); mute_n = 1'b1; tick(4);
    rd(3'd0, "R5 norst both", 8'hff);

    // R5 mute overrides a same-cycle write
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h80);
    mute_n = 1'b0; tick(MQ + 1);
    wr(3'd0, 8'hff);
    rd(3'd0, "R5 mute beats write", 8'ha0);
    mute_n = 1'b1; tick(4);

    // R6 back to sleep floats all
    wr(3'd0, 8'h00);
    now_chk("R6 sleep hiz", {1'b0, hiz}, 8'h7f);

    tick(2);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule